// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a stereo PCM bit stream into parallel samples. The stream arrives on three wires: a bit clock, a word clock at the sample rate, and a data line. All three are treated as ordinary inputs and oversampled by a faster system clock. The data line is taken on each detected rising edge of the bit clock. Words are two's complement, most significant bit first.

A 3-bit code picks one of three framings and the word length. Right-justified placement runs at 16, 20 or 24 bits. Left-justified runs at 24 bits. I2S runs at 16 or 24 bits. A separate polarity bit sets which word clock level is the left channel for the non-I2S framings.

Each captured word is sign-extended to 24 bits. A left word is held in a staging register. When the matching right word arrives, both output registers update together and a one-cycle valid strobe is raised.

A small controller walks four states:
- **IDLE**: after reset, waiting for the first bit clock edge.
- **ALIGN**: waiting for a word clock transition, so that the first half-frame is complete.
- **RUN**: capturing.
- **HOLD**: parked while a reserved code is applied.

The transitions are:
- IDLE→ALIGN on the first bit event.
- IDLE/ALIGN/RUN→HOLD when the code is reserved.
- ALIGN→RUN on a word clock transition.
- RUN→ALIGN when the code or the polarity changes.
- HOLD→ALIGN when a valid code returns.

Top module: `aud_rx`

## Requirements
- R1: While reset is low, and after it until the first complete stereo frame is captured, both sample outputs read zero and the valid strobe is low.
- R2: Code 000 (16-bit), 001 (20-bit) and 010 (24-bit) select right-justified placement. The word is the last N bits sampled before the word clock changes level, and any earlier bits of that half-frame are ignored.
- R3: Code 011 selects 24-bit left-justified placement. The most significant bit is the first bit sampled at the new word clock level.
- R4: Code 100 (16-bit) and 101 (24-bit) select I2S. The most significant bit is sampled one bit clock after the word clock changes. The left channel is the low word clock level, whatever the polarity bit.
- R5: For codes 000 to 011, a polarity bit of 0 maps word clock high to left and low to right; a polarity bit of 1 swaps the mapping.
- R6: 16-bit and 20-bit words appear on the 24-bit outputs sign-extended, with bit N-1 copied into every bit above it.
- R7: The valid strobe is high for exactly one system clock cycle per frame. It rises after a right word completes a frame whose left word was captured before it. Both outputs change only in that cycle.
- R8: Codes 110 and 111 are reserved. While one is applied the outputs keep their previous values and no valid strobe is produced. Capture resumes after a valid code returns.
- R9: Decoding works at 32, 48 and 64 bit clocks per sample period, provided each half-frame holds at least N bits (N+1 for I2S).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| bck_i | input | 1 | Serial bit clock |
| lrck_i | input | 1 | Word clock at the sample rate |
| din_i | input | 1 | Serial data, MSB first, two's complement |
| fmt_code_i | input | 3 | Framing and word length code (R2, R3, R4, R8) |
| lr_pol_i | input | 1 | Word clock polarity for non-I2S framings (R5) |
| left_o | output | 24 | Sign-extended left sample |
| right_o | output | 24 | Sign-extended right sample |
| valid_o | output | 1 | One-cycle strobe when a new stereo pair is presented |

## Verification
Each code is driven with left and right words of opposite sign and with asymmetric bit patterns. A swapped channel, a misplaced MSB or a missing sign extension therefore shows up as a different value.

Padding bits are set to one around every word. A decoder that takes bits from the wrong end of the half-frame, or that is one bit early or late, reads ones and fails.

Both polarity settings are run under right-justified, left-justified and I2S framing. This separates true polarity handling from the fixed I2S mapping.

Short half-frames of 16 and 24 bit clocks confirm that the first bit after a transition and the last bit before one are each found when no padding exists. A reserved-code run with fresh data confirms that neither the outputs nor the strobe move.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

    typedef enum logic [1:0] {
        FR_RJ  = 2'd0,
        FR_LJ  = 2'd1,
        FR_I2S = 2'd2
    } framing_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_RUN   = 2'd2,
        ST_HOLD  = 2'd3
    } rx_state_e;

    typedef struct packed {
        framing_e   framing;
        logic [4:0] wlen;
        logic       reserved;
    } fmt_t;

    // Code bit 2 picks I2S, bits 1:0 the length or the justification.
    function automatic fmt_t decode_fmt(input logic [2:0] code);
        fmt_t f;
        f.framing  = FR_RJ;
        f.wlen     = 5'd16;
        f.reserved = 1'b0;
        case (code)
            3'b000: begin f.framing = FR_RJ;  f.wlen = 5'd16; end
            3'b001: begin f.framing = FR_RJ;  f.wlen = 5'd20; end
            3'b010: begin f.framing = FR_RJ;  f.wlen = 5'd24; end
            3'b011: begin f.framing = FR_LJ;  f.wlen = 5'd24; end
            3'b100: begin f.framing = FR_I2S; f.wlen = 5'd16; end
            3'b101: begin f.framing = FR_I2S; f.wlen = 5'd24; end
            default: f.reserved = 1'b1;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/aud_rx_ctrl.sv
module aud_rx_ctrl
    import aud_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_evt,
    input  logic       lr_s,
    input  logic [2:0] code_i,
    input  logic       pol_i,
    input  logic       reserved,
    output logic       edge_evt,
    output logic       cap_en
);

    rx_state_e  state_q, state_d;
    logic       lr_prev_q;
    logic [3:0] cfg_q;
    logic       cfg_chg;

    assign cfg_chg = ({code_i, pol_i} != cfg_q);

    // Word clock level seen at the previous bit event, and the last configuration.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lr_prev_q <= 1'b0;
            cfg_q     <= '0;
        end else begin
            cfg_q <= {code_i, pol_i};
            if (bit_evt) lr_prev_q <= lr_s;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (reserved)     state_d = ST_HOLD;
                else if (bit_evt) state_d = ST_ALIGN;
            end
            ST_ALIGN: begin
                if (reserved)      state_d = ST_HOLD;
                else if (edge_evt) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (reserved)     state_d = ST_HOLD;
                else if (cfg_chg) state_d = ST_ALIGN;
            end
            ST_HOLD: begin
                if (!reserved) state_d = ST_ALIGN;
            end
        endcase
    end

    // Outputs.
    always_comb begin
        edge_evt = 1'b0;
        cap_en   = 1'b0;
        unique case (state_q)
            ST_IDLE:  edge_evt = 1'b0;
            ST_ALIGN: edge_evt = bit_evt && (lr_s != lr_prev_q);
            ST_RUN: begin
                edge_evt = bit_evt && (lr_s != lr_prev_q);
                cap_en   = !reserved && !cfg_chg;
            end
            ST_HOLD:  edge_evt = bit_evt && (lr_s != lr_prev_q);
        endcase
    end

endmodule

// File: rtl/aud_rx_datapath.sv
module aud_rx_datapath
    import aud_rx_pkg::*;
#(
    parameter int OUT_W = 24,
    parameter int SR_W  = 32,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_evt,
    input  logic             din_s,
    input  logic             lr_s,
    input  logic             edge_evt,
    input  logic             cap_en,
    input  framing_e         framing,
    input  logic [4:0]       wlen,
    input  logic             pol_i,
    output logic [OUT_W-1:0] left_o,
    output logic [OUT_W-1:0] right_o,
    output logic             valid_o
);

    logic [SR_W-1:0]         sr_q, sr_d;
    logic [CNT_W-1:0]        cnt_q, idx;
    logic [OUT_W-1:0]        src;
    logic                    hit, lvl, is_left;
    logic signed [OUT_W-1:0] aligned, ext;
    logic [OUT_W-1:0]        left_stage_q;
    logic                    got_left_q;
    int                      shift;

    // Shift register of incoming bits, and the index of the bit within its half-frame.
    always_comb begin
        sr_d = {sr_q[SR_W-2:0], din_s};
        if (edge_evt)           idx = '0;
        else if (cnt_q == '1)   idx = cnt_q;
        else                    idx = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= '0;
            cnt_q <= '1;
        end else if (bit_evt) begin
            sr_q  <= sr_d;
            cnt_q <= idx;
        end
    end

    // Decide when a word is complete, where it sits and which channel owns it.
    always_comb begin
        hit = 1'b0;
        src = sr_d[OUT_W-1:0];
        lvl = lr_s;
        unique case (framing)
            FR_RJ: begin
                hit = edge_evt;
                src = sr_q[OUT_W-1:0];
                lvl = ~lr_s;
            end
            FR_LJ: begin
                hit = (int'(idx) == int'(wlen) - 1);
            end
            FR_I2S: begin
                hit = (int'(idx) == int'(wlen));
            end
            default: hit = 1'b0;
        endcase
        hit     = hit && bit_evt && cap_en;
        is_left = (framing == FR_I2S) ? ~lvl : (lvl ^ pol_i);
    end

    // Sign extension from the selected word length.
    always_comb begin
        shift   = OUT_W - int'(wlen);
        aligned = signed'(src << shift);
        ext     = aligned >>> shift;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_stage_q <= '0;
            got_left_q   <= 1'b0;
            left_o       <= '0;
            right_o      <= '0;
            valid_o      <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (!cap_en) begin
                got_left_q <= 1'b0;
            end else if (hit) begin
                if (is_left) begin
                    left_stage_q <= ext;
                    got_left_q   <= 1'b1;
                end else if (got_left_q) begin
                    left_o     <= left_stage_q;
                    right_o    <= ext;
                    valid_o    <= 1'b1;
                    got_left_q <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/aud_rx.sv
module aud_rx
    import aud_rx_pkg::*;
#(
    parameter int OUT_W       = 24,
    parameter int SYNC_STAGES = 2,
    parameter int MAX_HALF    = 32,
    localparam int CNT_W      = $clog2(MAX_HALF) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bck_i,
    input  logic             lrck_i,
    input  logic             din_i,
    input  logic [2:0]       fmt_code_i,
    input  logic             lr_pol_i,
    output logic [OUT_W-1:0] left_o,
    output logic [OUT_W-1:0] right_o,
    output logic             valid_o
);

    logic [2:0] pins_s;
    logic       bck_s, lr_s, din_s, bck_d_q, bit_evt;
    logic       edge_evt, cap_en;
    fmt_t       fmt;

    aud_rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({bck_i, lrck_i, din_i}),
        .sync_o  (pins_s)
    );

    assign {bck_s, lr_s, din_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bck_d_q <= 1'b0;
        else        bck_d_q <= bck_s;
    end

    assign bit_evt = bck_s && !bck_d_q;
    assign fmt     = decode_fmt(fmt_code_i);

    aud_rx_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_evt  (bit_evt),
        .lr_s     (lr_s),
        .code_i   (fmt_code_i),
        .pol_i    (lr_pol_i),
        .reserved (fmt.reserved),
        .edge_evt (edge_evt),
        .cap_en   (cap_en)
    );

    aud_rx_datapath #(.OUT_W(OUT_W), .SR_W(MAX_HALF), .CNT_W(CNT_W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_evt  (bit_evt),
        .din_s    (din_s),
        .lr_s     (lr_s),
        .edge_evt (edge_evt),
        .cap_en   (cap_en),
        .framing  (fmt.framing),
        .wlen     (fmt.wlen),
        .pol_i    (lr_pol_i),
        .left_o   (left_o),
        .right_o  (right_o),
        .valid_o  (valid_o)
    );

endmodule

// File: rtl/aud_rx_checker.sv
module aud_rx_checker #(
    parameter int OUT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       code,
    input logic             valid,
    input logic [OUT_W-1:0] left,
    input logic [OUT_W-1:0] right
);

    logic code_reserved;
    assign code_reserved = (code[2:1] == 2'b11);

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    assert_out_only_on_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> ($stable(left) && $stable(right)));

    assert_no_valid_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
        code_reserved |=> !valid);

    assert_hold_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
        code_reserved |=> ($stable(left) && $stable(right)));

endmodule

bind aud_rx aud_rx_checker #(.OUT_W(OUT_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .code  (fmt_code_i),
    .valid (valid_o),
    .left  (left_o),
    .right (right_o)
);

// File: tb/aud_rx_bench.sv
module aud_rx_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bck = 1'b0;
    logic        lrck = 1'b0;
    logic        din = 1'b0;
    logic [2:0]  code = 3'b000;
    logic        pol = 1'b0;
    logic [23:0] left_o, right_o;
    logic        valid_o;

    int nchk = 0;
    int nfail = 0;
    int vcount = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    aud_rx u_aud_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .bck_i      (bck),
        .lrck_i     (lrck),
        .din_i      (din),
        .fmt_code_i (code),
        .lr_pol_i   (pol),
        .left_o     (left_o),
        .right_o    (right_o),
        .valid_o    (valid_o)
    );

    always @(posedge clk) if (valid_o) vcount <= vcount + 1;

    typedef struct packed {
        logic [2:0]  code;
        logic        pol;
        logic [5:0]  half;
        logic [23:0] l_in;
        logic [23:0] r_in;
        logic [23:0] l_exp;
        logic [23:0] r_exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{3'b000, 1'b0, 6'd32, 24'h008001, 24'h007FFE, 24'hFF8001, 24'h007FFE}, // R2 R6
        '{3'b001, 1'b0, 6'd32, 24'h080000, 24'h012345, 24'hF80000, 24'h012345}, // R2 R6
        '{3'b010, 1'b1, 6'd32, 24'hA5A5A5, 24'h5A5A5A, 24'hA5A5A5, 24'h5A5A5A}, // R2 R5
        '{3'b011, 1'b0, 6'd32, 24'h800000, 24'h7FFFFF, 24'h800000, 24'h7FFFFF}, // R3
        '{3'b011, 1'b1, 6'd32, 24'h123456, 24'hFEDCBA, 24'h123456, 24'hFEDCBA}, // R3 R5
        '{3'b100, 1'b0, 6'd32, 24'h00C000, 24'h000001, 24'hFFC000, 24'h000001}, // R4 R6
        '{3'b101, 1'b1, 6'd32, 24'hDEAD01, 24'h0BEEF0, 24'hDEAD01, 24'h0BEEF0}, // R4
        '{3'b000, 1'b1, 6'd16, 24'h001234, 24'h00F0F0, 24'h001234, 24'hFFF0F0}, // R9 R5
        '{3'b011, 1'b0, 6'd24, 24'hC0FFEE, 24'h13579B, 24'hC0FFEE, 24'h13579B}, // R9 R3
        '{3'b100, 1'b1, 6'd32, 24'h007FFF, 24'h008000, 24'h007FFF, 24'hFF8000}  // R4 polarity ignored
    };

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic lv, input logic d);
        @(negedge clk);
        bck  = 1'b0;
        lrck = lv;
        din  = d;
        repeat (4) @(negedge clk);
        bck = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    function automatic int wlen_of(input logic [2:0] c);
        case (c)
            3'b001:                 return 20;
            3'b010, 3'b011, 3'b101: return 24;
            default:                return 16;
        endcase
    endfunction

    task automatic send_half(input logic [2:0] c, input logic p, input logic is_left,
                             input logic [23:0] w, input int half);
        int   n;
        logic lv;
        logic b;
        n  = wlen_of(c);
        lv = c[2] ? ~is_left : (is_left ? ~p : p);
        for (int k = 0; k < half; k++) begin
            b = 1'b1;
            if (c[2]) begin
                if (k >= 1 && k <= n) b = w[n-k];
            end else if (c == 3'b011) begin
                if (k < n) b = w[n-1-k];
            end else begin
                if (k >= half - n) b = w[n-1-(k-(half-n))];
            end
            send_bit(lv, b);
        end
    endtask

    task automatic send_frames(input int nfr, input logic [2:0] c, input logic p,
                               input logic [23:0] l, input logic [23:0] r, input int half);
        for (int f = 0; f < nfr; f++) begin
            send_half(c, p, 1'b1, l, half);
            send_half(c, p, 1'b0, r, half);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            nchk++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        check("R1 left during reset", left_o, 24'h0);
        check("R1 right during reset", right_o, 24'h0);
        check("R1 valid during reset", {23'h0, valid_o}, 24'h0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        send_half(3'b000, 1'b0, 1'b1, 24'h00ABCD, 32);
        check("R1 left before full frame", left_o, 24'h0);
        check("R1 valid before full frame", vcount, 0);

        for (int v = 0; v < NV; v++) begin
            code   = VECS[v].code;
            pol    = VECS[v].pol;
            vcount = 0;
            send_frames(4, VECS[v].code, VECS[v].pol, VECS[v].l_in, VECS[v].r_in,
                        int'(VECS[v].half));
            repeat (4) @(negedge clk);
            check($sformatf("vec %0d left R2 R3 R4 R5 R6 R9", v), left_o, VECS[v].l_exp);
            check($sformatf("vec %0d right R2 R3 R4 R5 R6 R9", v), right_o, VECS[v].r_exp);
            check($sformatf("vec %0d R7 strobe seen", v), {23'h0, (vcount >= 1)}, 24'h1);
        end

        // R8: reserved code holds outputs and strobes nothing
        code   = 3'b110;
        vcount = 0;
        send_frames(3, 3'b110, 1'b0, 24'h111111, 24'h222222, 32);
        repeat (4) @(negedge clk);
        check("R8 left held", left_o, VECS[NV-1].l_exp);
        check("R8 right held", right_o, VECS[NV-1].r_exp);
        check("R8 no strobe", vcount, 0);

        code   = 3'b111;
        vcount = 0;
        send_frames(2, 3'b111, 1'b1, 24'h333333, 24'h444444, 32);
        repeat (4) @(negedge clk);
        check("R8 code 111 no strobe", vcount, 0);

        // R8: recovery after a valid code returns
        code   = 3'b010;
        pol    = 1'b0;
        vcount = 0;
        send_frames(4, 3'b010, 1'b0, 24'h654321, 24'h9ABCDE, 32);
        repeat (4) @(negedge clk);
        check("R8 resume left", left_o, 24'h654321);
        check("R8 resume right", right_o, 24'h9ABCDE);

        // R7: one strobe per frame, each a single cycle wide
        vcount = 0;
        send_frames(3, 3'b010, 1'b0, 24'h654321, 24'h9ABCDE, 32);
        repeat (4) @(negedge clk);
        check("R7 strobes per 3 frames", {23'h0, (vcount >= 2 && vcount <= 3)}, 24'h1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule